// File: doc/BRIEF.md
# Segmented Pretrigger Ring-Buffer Controller

This block drives the write side of a cyclic sample memory for a fast acquisition channel. Memory is split into equal, back-to-back segments whose size is a power of two from 256 samples upward. Each segment works as its own ring. Samples are written around the ring while the block waits for a trigger. A trigger is honoured only after a programmed minimum of pretrigger samples has been stored in the current segment. An accepted trigger loads a posttrigger down-counter, and that segment closes once the counter has counted the programmed number of further samples.

When a segment closes, the block moves on at once to the next segment, with no idle cycle between them. It stops after the last configured segment and raises a done level. For every segment it records the in-segment offset where posttrigger data begins, so readout can unwrap the ring. If the posttrigger count is larger than the segment, the ring wraps and overwrites older samples, which gives a pure delay after the trigger.

Samples arrive on a valid/ready stream. The controller holds ready high only while it is acquiring (waiting for a trigger, or counting posttrigger samples). While ready is low, an upstream source must hold its sample, and nothing is written. A write happens in exactly the cycles where valid and ready are both high. The memory address and write enable are combinational from the current state and valid.

Top module: `rbc_top`

## Requirements
- R1: After reset the block is idle: s_ready, mem_we, seg_done and acq_done are all 0, and every stored trigger offset reads 0.
- R2: The write address is the segment index shifted left by (8 + size select), ORed with the in-segment offset. The offset starts at 0 and wraps modulo the segment size, which is 256 shifted left by the size select.
- R3: s_ready is 1 only while waiting for a trigger or counting posttrigger samples. mem_we is 1 exactly when s_valid and s_ready are both 1.
- R4: A trigger is accepted only while waiting for one, and only if the writes already made in the current segment (before that cycle) number at least cfg_pre. Any other trigger is ignored.
- R5: After an accepted trigger, exactly cfg_post further writes close the segment. The sample written in the trigger cycle counts as pretrigger. seg_done is a one-cycle pulse in the cycle after the closing write, and seg_done_idx gives the closed segment's index.
- R6: On an accepted trigger, the offset of the first posttrigger sample is stored for that segment. That is the offset following any write in the trigger cycle. rd_trig_pos returns the value stored for segment rd_seg.
- R7: When a segment that is not the last one closes, s_ready stays 1 in the next cycle. The segment index increments, the offset restarts at 0, and the pretrigger count restarts at 0.
- R8: When segment cfg_nseg_m1 closes, acq_done rises together with seg_done. s_ready then stays 0 and no write occurs until the next start.
- R9: stop_cmd returns the block to idle in the next cycle, with no segment closing and acq_done unchanged. It takes priority over start_cmd and trig_in in the same cycle.
- R10: start_cmd (without stop_cmd) clears acq_done and restarts at segment 0, offset 0, with pretrigger count 0, from any state.
- R11: With cfg_post equal to 0, an accepted trigger closes the segment in the trigger cycle itself.
- R12: A size select above the largest supported value (MAX_OFS_W - 8) acts as the largest supported value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_cmd | input | 1 | Begin a new acquisition |
| stop_cmd | input | 1 | Abort to idle |
| trig_in | input | 1 | Trigger event |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| cfg_size_sel | input | SEL_W | Segment size select, size = 256 << sel |
| cfg_nseg_m1 | input | SEG_W | Number of segments minus one |
| cfg_pre | input | CNT_W | Minimum pretrigger samples per segment |
| cfg_post | input | CNT_W | Posttrigger sample count |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| seg_done | output | 1 | Segment closed pulse |
| seg_done_idx | output | SEG_W | Index of closed segment |
| acq_done | output | 1 | Whole acquisition complete |
| rd_seg | input | SEG_W | Segment select for trigger offset readout |
| rd_trig_pos | output | MAX_OFS_W | Stored trigger offset of segment rd_seg |

## Verification
Two collisions matter most. The first is a trigger that lands in exactly the cycle where the pretrigger count first reaches cfg_pre. The second is a segment close that falls in the cycle right before the next segment's first write, where any dead cycle would show up as ready dropping. The bench provokes the first by pulsing the trigger once too early, then again exactly when the threshold is met. It provokes the second by running cfg_pre = 0 and cfg_post = 0 with the trigger held high, so segments close on consecutive cycles. A behavioural model judges ready, write enable, address, the done pulses and the stored offsets every cycle. A stop issued together with a trigger, and a stop issued together with a start, are checked against the priority rules in the same way.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } rbc_state_e;

  // smallest segment is 2**MIN_OFS_W samples
  localparam int MIN_OFS_W = 8;
endpackage

// File: rtl/rbc_ofs_gen.sv
module rbc_ofs_gen #(
  parameter int OFS_W  = 10,
  parameter int SEG_W  = 3,
  parameter int SEL_W  = 4,
  parameter int ADDR_W = OFS_W + SEG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic              next_seg,
  input  logic [SEL_W-1:0]  size_sel,
  output logic [OFS_W-1:0]  ofs,
  output logic [OFS_W-1:0]  ofs_nxt,
  output logic [SEG_W-1:0]  seg,
  output logic [ADDR_W-1:0] addr
);
  localparam int MAX_SEL = OFS_W - rbc_pkg::MIN_OFS_W;

  logic [SEL_W-1:0] sel_eff;
  logic [OFS_W-1:0] wrap_mask;

  always_comb begin
    sel_eff   = (size_sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : size_sel;
    wrap_mask = ~({OFS_W{1'b1}} << (rbc_pkg::MIN_OFS_W + int'(sel_eff)));
    ofs_nxt   = adv ? ((ofs + 1'b1) & wrap_mask) : ofs;
    addr      = (ADDR_W'(seg) << (rbc_pkg::MIN_OFS_W + int'(sel_eff))) | ADDR_W'(ofs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs <= '0;
      seg <= '0;
    end else if (clr) begin
      ofs <= '0;
      seg <= '0;
    end else if (next_seg) begin
      ofs <= '0;
      seg <= seg + 1'b1;
    end else begin
      ofs <= ofs_nxt;
    end
  end
endmodule

// File: rtl/rbc_win.sv
module rbc_win #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic             in_arm,
  input  logic             in_post,
  input  logic             trig,
  input  logic             load,
  input  logic [CNT_W-1:0] cfg_pre,
  input  logic [CNT_W-1:0] cfg_post,
  output logic             trig_ok,
  output logic             post_end
);
  logic [CNT_W-1:0] pre_cnt;
  logic [CNT_W-1:0] post_cnt;

  // pretrigger fill, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pre_cnt <= '0;
    else if (clr)                   pre_cnt <= '0;
    else if (we && pre_cnt != '1)   pre_cnt <= pre_cnt + 1'b1;
  end

  // posttrigger down-counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  post_cnt <= '0;
    else if (load)                               post_cnt <= cfg_post;
    else if (in_post && we && post_cnt != '0)    post_cnt <= post_cnt - 1'b1;
  end

  always_comb begin
    trig_ok  = in_arm && trig && (pre_cnt >= cfg_pre);
    post_end = in_post && we && (post_cnt == CNT_W'(1));
  end
endmodule

// File: rtl/rbc_pos_store.sv
module rbc_pos_store #(
  parameter int OFS_W = 10,
  parameter int SEG_W = 3,
  parameter int NSEG  = 1 << SEG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEG_W-1:0] wr_idx,
  input  logic [OFS_W-1:0] wr_pos,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [OFS_W-1:0] rd_pos
);
  logic [OFS_W-1:0] slots [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_slot
    logic [OFS_W-1:0] pos_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               pos_q <= '0;
      else if (wr_en && wr_idx == SEG_W'(g))    pos_q <= wr_pos;
    end
    assign slots[g] = pos_q;
  end

  assign rd_pos = slots[rd_idx];
endmodule

// File: rtl/rbc_top.sv
module rbc_top #(
  parameter int MAX_OFS_W = 10,
  parameter int SEG_W     = 3,
  parameter int SEL_W     = 4,
  localparam int ADDR_W   = MAX_OFS_W + SEG_W,
  localparam int CNT_W    = MAX_OFS_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_cmd,
  input  logic                 stop_cmd,
  input  logic                 trig_in,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [SEL_W-1:0]     cfg_size_sel,
  input  logic [SEG_W-1:0]     cfg_nseg_m1,
  input  logic [CNT_W-1:0]     cfg_pre,
  input  logic [CNT_W-1:0]     cfg_post,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 seg_done,
  output logic [SEG_W-1:0]     seg_done_idx,
  output logic                 acq_done,
  input  logic [SEG_W-1:0]     rd_seg,
  output logic [MAX_OFS_W-1:0] rd_trig_pos
);
  import rbc_pkg::*;

  rbc_state_e state_q, state_d;

  logic in_arm, in_post, run, do_start;
  logic trig_ok, post_end, accept, seg_end, last_seg, next_seg;
  logic [MAX_OFS_W-1:0] ofs, ofs_nxt;
  logic [SEG_W-1:0]     seg;

  always_comb begin
    in_arm   = (state_q == ST_ARM);
    in_post  = (state_q == ST_POST);
    s_ready  = in_arm || in_post;
    mem_we   = s_valid && s_ready;
    run      = !stop_cmd && !start_cmd;
    do_start = start_cmd && !stop_cmd;
    accept   = trig_ok && run;
    seg_end  = run && ((accept && cfg_post == '0) || post_end);
    last_seg = (seg == cfg_nseg_m1);
    next_seg = seg_end && !last_seg;
  end

  rbc_ofs_gen #(
    .OFS_W (MAX_OFS_W),
    .SEG_W (SEG_W),
    .SEL_W (SEL_W),
    .ADDR_W(ADDR_W)
  ) u_ofs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (do_start),
    .adv     (mem_we && !stop_cmd),
    .next_seg(next_seg),
    .size_sel(cfg_size_sel),
    .ofs     (ofs),
    .ofs_nxt (ofs_nxt),
    .seg     (seg),
    .addr    (mem_addr)
  );

  rbc_win #(.CNT_W(CNT_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (do_start || next_seg),
    .we      (mem_we),
    .in_arm  (in_arm),
    .in_post (in_post),
    .trig    (trig_in),
    .load    (accept),
    .cfg_pre (cfg_pre),
    .cfg_post(cfg_post),
    .trig_ok (trig_ok),
    .post_end(post_end)
  );

  rbc_pos_store #(
    .OFS_W(MAX_OFS_W),
    .SEG_W(SEG_W)
  ) u_pos (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (accept),
    .wr_idx(seg),
    .wr_pos(ofs_nxt),
    .rd_idx(rd_seg),
    .rd_pos(rd_trig_pos)
  );

  always_comb begin
    state_d = state_q;
    if (stop_cmd)       state_d = ST_IDLE;
    else if (start_cmd) state_d = ST_ARM;
    else if (seg_end)   state_d = last_seg ? ST_DONE : ST_ARM;
    else if (accept)    state_d = ST_POST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      seg_done     <= 1'b0;
      seg_done_idx <= '0;
      acq_done     <= 1'b0;
    end else begin
      state_q  <= state_d;
      seg_done <= seg_end;
      if (seg_end) seg_done_idx <= seg;
      if (do_start)                  acq_done <= 1'b0;
      else if (seg_end && last_seg)  acq_done <= 1'b1;
    end
  end
endmodule

// File: rtl/rbc_checker.sv
module rbc_checker #(
  parameter int MAX_OFS_W = 10,
  parameter int SEG_W     = 3,
  parameter int SEL_W     = 4,
  localparam int ADDR_W   = MAX_OFS_W + SEG_W,
  localparam int CNT_W    = MAX_OFS_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_cmd,
  input logic              stop_cmd,
  input logic              s_ready,
  input logic              mem_we,
  input logic              seg_done,
  input logic [SEG_W-1:0]  seg_done_idx,
  input logic              acq_done,
  input logic [SEG_W-1:0]  cfg_nseg_m1
);
  assert_done_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acq_done |-> !mem_we);

  assert_done_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_done) |-> (seg_done && seg_done_idx == cfg_nseg_m1));

  assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_done && !acq_done) |-> s_ready);

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !s_ready);

  assert_start_arms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !stop_cmd) |=> (s_ready && !acq_done));
endmodule

bind rbc_top rbc_checker #(
  .MAX_OFS_W(MAX_OFS_W),
  .SEG_W    (SEG_W),
  .SEL_W    (SEL_W)
) u_rbc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_cmd   (start_cmd),
  .stop_cmd    (stop_cmd),
  .s_ready     (s_ready),
  .mem_we      (mem_we),
  .seg_done    (seg_done),
  .seg_done_idx(seg_done_idx),
  .acq_done    (acq_done),
  .cfg_nseg_m1 (cfg_nseg_m1)
);

// File: tb/tb_rbc_top.sv
module tb_rbc_top;
  localparam int MAX_OFS_W = 10;
  localparam int SEG_W     = 3;
  localparam int SEL_W     = 4;
  localparam int ADDR_W    = MAX_OFS_W + SEG_W;
  localparam int CNT_W     = MAX_OFS_W + 2;
  localparam int NSEG      = 1 << SEG_W;
  localparam int PRE_MAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_cmd = 0, stop_cmd = 0, trig_in = 0, s_valid = 0;
  logic [SEL_W-1:0] cfg_size_sel = '0;
  logic [SEG_W-1:0] cfg_nseg_m1 = '0;
  logic [CNT_W-1:0] cfg_pre = '0, cfg_post = '0;
  logic [SEG_W-1:0] rd_seg = '0;
  logic s_ready, mem_we, seg_done, acq_done;
  logic [ADDR_W-1:0] mem_addr;
  logic [SEG_W-1:0] seg_done_idx;
  logic [MAX_OFS_W-1:0] rd_trig_pos;

  always #5 clk = ~clk;

  rbc_top #(.MAX_OFS_W(MAX_OFS_W), .SEG_W(SEG_W), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .trig_in(trig_in), .s_valid(s_valid), .s_ready(s_ready),
    .cfg_size_sel(cfg_size_sel), .cfg_nseg_m1(cfg_nseg_m1),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .mem_we(mem_we), .mem_addr(mem_addr),
    .seg_done(seg_done), .seg_done_idx(seg_done_idx), .acq_done(acq_done),
    .rd_seg(rd_seg), .rd_trig_pos(rd_trig_pos)
  );

  // behavioural reference: 0 idle, 1 waiting for trigger, 2 posttrigger, 3 done
  int m_st = 0, m_seg = 0, m_ofs = 0, m_pre = 0, m_post = 0, m_sdi = 0;
  bit m_done = 0, m_sd = 0;
  int m_tp [NSEG];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit gap_mode = 0, finished = 0;

  task automatic chk(input int act, input int exp, input string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", what, cyc, act, exp);
    end
  endtask

  function automatic int seg_size();
    int s = (cfg_size_sel > 2) ? 2 : int'(cfg_size_sel);  // R12 clamp
    return 256 << s;
  endfunction

  task automatic compare();
    bit e_ready = (m_st == 1 || m_st == 2);
    bit e_we = s_valid && e_ready;
    chk(s_ready, e_ready, "R3 s_ready");
    chk(mem_we, e_we, "R3 mem_we");
    if (e_we) chk(mem_addr, m_seg * seg_size() + m_ofs, "R2 mem_addr");
    chk(seg_done, m_sd, "R5 seg_done");
    if (m_sd) chk(seg_done_idx, m_sdi, "R5 seg_done_idx");
    chk(acq_done, m_done, "R8 acq_done");
    chk(rd_trig_pos, m_tp[rd_seg], "R6 rd_trig_pos");
  endtask

  task automatic model_upd();
    bit we = s_valid && (m_st == 1 || m_st == 2);
    bit endf = 0;
    int nofs;
    if (stop_cmd) begin                      // R9 stop wins
      m_st = 0; m_sd = 0;
    end else if (start_cmd) begin            // R10
      m_st = 1; m_seg = 0; m_ofs = 0; m_pre = 0; m_done = 0; m_sd = 0;
    end else if (m_st == 1 || m_st == 2) begin
      nofs = we ? (m_ofs + 1) % seg_size() : m_ofs;
      if (m_st == 1) begin
        if (trig_in && m_pre >= int'(cfg_pre)) begin   // R4
          m_tp[m_seg] = nofs;                          // R6
          if (cfg_post == 0) endf = 1;                 // R11
          else begin m_post = int'(cfg_post); m_st = 2; end
        end
        if (we && m_pre < PRE_MAX) m_pre++;
      end else if (we) begin
        m_post--;
        if (m_post == 0) endf = 1;                     // R5
      end
      m_ofs = nofs;
      m_sd = endf;
      if (endf) begin
        m_sdi = m_seg;
        if (m_seg == int'(cfg_nseg_m1)) begin m_st = 3; m_done = 1; end  // R8
        else begin m_seg++; m_ofs = 0; m_pre = 0; m_st = 1; end          // R7
      end
    end else m_sd = 0;
  endtask

  task automatic step();
    if (gap_mode) s_valid = (cyc % 3 != 0);
    rd_seg = SEG_W'(cyc);
    #1;
    compare();
    @(posedge clk);
    model_upd();
    cyc++;
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_start();
    start_cmd = 1; step(); start_cmd = 0;
  endtask

  task automatic pulse_trig();
    trig_in = 1; step(); trig_in = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cyc);
    summary();
  end

  initial begin
    for (int i = 0; i < NSEG; i++) m_tp[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle outputs after reset
    steps(4);

    // Test A: two segments, early trigger ignored, trigger at threshold (R4, R5, R6, R7, R8)
    cfg_size_sel = 0; cfg_nseg_m1 = 1; cfg_pre = 10; cfg_post = 20;
    s_valid = 1;
    pulse_start();
    steps(3);
    pulse_trig();          // R4: only 3 pretrigger samples so far, ignored
    steps(6);
    pulse_trig();          // R4: count equals cfg_pre, accepted
    steps(5);
    pulse_trig();          // R4: trigger during posttrigger ignored
    steps(20);             // R5/R7: segment closes, next starts without gap
    steps(12);
    pulse_trig();
    steps(25);             // R8: done
    steps(5);              // R8: valid high, no writes

    // Test B: 512-sample ring wraps, valid gaps (R2, R10)
    gap_mode = 1;
    cfg_size_sel = 1; cfg_nseg_m1 = 0; cfg_pre = 300; cfg_post = 600;
    pulse_start();         // R10 clears done
    steps(400);
    pulse_trig();
    steps(1000);
    gap_mode = 0; s_valid = 1;

    // Test C: clamped size, zero pre/post, back-to-back closes (R11, R12, R7)
    cfg_size_sel = 7; cfg_nseg_m1 = 2; cfg_pre = 0; cfg_post = 0;
    pulse_start();
    trig_in = 1;
    steps(5);
    trig_in = 0;
    steps(3);

    // Test C2: large segment address check with clamped select (R12, R2)
    cfg_nseg_m1 = 3; cfg_pre = 2; cfg_post = 1100;
    pulse_start();
    steps(3);
    pulse_trig();
    steps(1120);

    // Test D: stop priority and restart (R9, R10)
    cfg_size_sel = 0; cfg_nseg_m1 = 3; cfg_pre = 5; cfg_post = 50;
    pulse_start();
    steps(20);
    pulse_trig();
    steps(10);
    stop_cmd = 1; trig_in = 1; step(); stop_cmd = 0; trig_in = 0;   // R9
    steps(3);
    stop_cmd = 1; start_cmd = 1; step(); stop_cmd = 0; start_cmd = 0; // R9
    steps(2);
    pulse_start();
    steps(10);
    pulse_start();         // R10 restart mid-run
    steps(8);
    pulse_trig();
    steps(60);
    s_valid = 0;
    steps(4);
    summary();
  end
endmodule